// File: doc/BRIEF.md
# Serial Configuration Stream Parser

This block takes in a configuration stream one item per clock, qualified by a valid strobe, and takes it apart into its fields. In the default bit-serial mode it waits for a run of at least eight ones and a four-bit preamble, then loads a 24-bit length count and a separator of ones. It then cuts the payload into frames. Each frame has a single start bit, a fixed number of data bits and a four-bit check field. It counts the frame bits against the loaded length, then expects a postamble and finally four don't-care start-up items. In the byte-wide mode, one byte arrives per clock with D0 as the first bit. That mode has no length count and no checking: a fixed number of frames is followed by the four start-up items.

Data bits (or bytes) leave on `dout` with `dout_valid`, and a `frame_end` strobe marks each accepted frame. `header_ok` reports that the header is complete, `done` reports a finished stream, and `err` reports a malformed one. Any deviation from the format sends the controller to a terminal error state until reset.

Controller states: IDLE (picks the mode branch and handles the first item), ONES, PRE, LEN, SEP, FSTART, FDATA, FCHK, POST, BOOT for serial mode; XONES, XPRE, XFILL, XFDATA, XBOOT for byte mode; DONE and ERR are terminal. Serial transitions: ONES→PRE on a zero after eight or more ones; PRE→LEN after four preamble bits; LEN→SEP after 24 bits; SEP→FSTART, or SEP→POST when the length is zero; FSTART→FDATA; FDATA→FCHK after the last data bit; FCHK→FSTART while the consumed count is below the length, FCHK→POST when it is equal; POST→BOOT; BOOT→DONE after four items. Byte transitions: XONES→XPRE→XFILL→XFDATA→XBOOT→DONE. Every check failure goes to ERR.

Top module: `cfg_stream_parser`

## Requirements
- R1: While reset is applied and after it is released, `dout_valid`, `frame_end`, `header_ok`, `done` and `err` are all low until a valid item changes them.
- R2: In serial mode (`wide_mode`=0) the header is eight or more ones, the preamble bits 0,0,1,0 in that order, a 24-bit length count sent MSB first, and SEP_BITS ones. `header_ok` rises one cycle after the last separator bit and then stays high.
- R3: In serial mode, a zero before the eighth leading one, a preamble bit that differs from 0,0,1,0, or a zero inside the separator raises `err` one cycle after that bit.
- R4: A serial frame is a start bit of 0, then FRAME_BITS data bits, then a 4-bit check sent MSB first. Each data bit appears on `dout[0]` with `dout_valid`, one cycle after it is accepted, with `dout[7:1]` zero. The check must equal the number of one bits among the data bits, modulo 16. `frame_end` pulses one cycle after the last check bit when the check matches.
- R5: A start bit of 1 or a mismatching check field raises `err`. No further `dout_valid` or `frame_end` follows.
- R6: The count of consumed frame bits covers start, data and check bits. When that count equals the length count at a frame end, the postamble follows; when it exceeds the length count, `err` rises. A zero length count leads straight from the separator to the postamble.
- R7: The serial postamble is the bits 0,1,1,0 in that order; any other bit raises `err`.
- R8: After the postamble (or, in byte mode, after the last frame), four valid items of any value follow. `done` rises one cycle after the fourth, stays high, and later input produces no output.
- R9: A cycle with `in_valid` low advances nothing and produces no `dout_valid`, `frame_end`, `done` or `err` change.
- R10: In byte mode (`wide_mode`=1) the header is the byte 0xFF, then a byte whose D0..D3 are 0,0,1,0 (low nibble 4'h4, upper nibble ignored), then three fill bytes of any value. `header_ok` rises one cycle after the third fill byte.
- R11: In byte mode each frame is FRAME_BITS/8 bytes presented on `dout` with `dout_valid`, with no start bit or check. `frame_end` is high together with the frame's last byte. After EXP_FRAMES frames, the start-up phase of R8 follows.
- R12: In byte mode, a first byte other than 0xFF or a preamble byte whose low nibble is not 4'h4 raises `err`.
- R13: `err` and `done` are sticky until reset and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 0: bit-serial stream, 1: byte-wide stream; held constant after reset |
| in_valid | input | 1 | Qualifies the current input item |
| in_bit | input | 1 | Serial-mode data bit |
| in_byte | input | 8 | Byte-mode data, bit 0 is first |
| dout_valid | output | 1 | A frame data item is on `dout` |
| dout | output | 8 | Frame data bit (bit 0) or frame data byte |
| frame_end | output | 1 | Frame accepted strobe |
| header_ok | output | 1 | Header fully received (sticky) |
| done | output | 1 | Stream complete including start-up items (sticky) |
| err | output | 1 | Format violation seen (sticky) |

## Verification
The hardest situation to reach from the ports is a frame that passes its own start and check tests while overrunning the length count. The overrun is only judged at a frame boundary, several dozen bits after the header. The stimulus loads a length that is not a multiple of the frame size and sends two good frames. It then expects the second frame's end strobe and the error together. Serial runs also leave periodic holes in the valid strobe so that every field counter must hold across stalls.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_ONES,
        ST_PRE,
        ST_LEN,
        ST_SEP,
        ST_FSTART,
        ST_FDATA,
        ST_FCHK,
        ST_POST,
        ST_BOOT,
        XT_ONES,
        XT_PRE,
        XT_FILL,
        XT_FDATA,
        XT_BOOT,
        ST_DONE,
        ST_ERR
    } cfgp_state_e;

    // serial preamble and postamble, leftmost bit arrives first
    localparam logic [3:0] PRE_CODE  = 4'b0010;
    localparam logic [3:0] POST_CODE = 4'b0110;
    localparam int         CHK_W     = 4;
    localparam int         MIN_ONES  = 8;
    localparam int         BOOT_ITEMS = 4;
    localparam int         X_FILL_BYTES = 3;
    localparam logic [7:0] X_ONES_BYTE = 8'hFF;
    localparam logic [3:0] X_PRE_NIB   = 4'h4;

endpackage

// File: rtl/cfgp_ckacc.sv
module cfgp_ckacc #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add,
    input  logic         bit_i,
    output logic [W-1:0] sum
);

    // running count of one bits, wraps modulo 2**W
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum <= '0;
        end else if (clr) begin
            sum <= '0;
        end else if (add && bit_i) begin
            sum <= sum + 1'b1;
        end
    end

endmodule

// File: rtl/cfgp_shreg.sv
module cfgp_shreg #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] q
);

    // first bit in ends up as the MSB
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (shift) begin
            q <= {q[W-2:0], din};
        end
    end

endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser
    import cfgp_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int SEP_BITS   = 4,
    parameter int LEN_W      = 24,
    parameter int EXP_FRAMES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wide_mode,
    input  logic       in_valid,
    input  logic       in_bit,
    input  logic [7:0] in_byte,
    output logic       dout_valid,
    output logic [7:0] dout,
    output logic       frame_end,
    output logic       header_ok,
    output logic       done,
    output logic       err
);

    localparam int FBYTES  = FRAME_BITS / 8;
    localparam int MAX_A   = (FRAME_BITS > LEN_W) ? FRAME_BITS : LEN_W;
    localparam int CNT_MAX = (MAX_A > SEP_BITS) ? MAX_A : SEP_BITS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int FC_W    = (EXP_FRAMES > 1) ? $clog2(EXP_FRAMES) : 1;

    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_LEN  = CNT_W'(LEN_W - 1);
    localparam logic [CNT_W-1:0] LAST_SEP  = CNT_W'(SEP_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(FBYTES - 1);
    localparam logic [CNT_W-1:0] LAST_CHK  = CNT_W'(CHK_W - 1);
    localparam logic [CNT_W-1:0] LAST_BOOT = CNT_W'(BOOT_ITEMS - 1);
    localparam logic [CNT_W-1:0] LAST_FILL = CNT_W'(X_FILL_BYTES - 1);
    localparam logic [CNT_W-1:0] ONES_MIN  = CNT_W'(MIN_ONES);
    localparam logic [FC_W-1:0]  LAST_FR   = FC_W'(EXP_FRAMES - 1);

    cfgp_state_e state, nxt, cur;

    logic [CNT_W-1:0] cnt, cnt_n;
    logic [LEN_W-1:0] used, used_n;
    logic [FC_W-1:0]  frames, frames_n;
    logic [LEN_W-1:0] len_q;
    logic [CHK_W-1:0] rx_q;
    logic [CHK_W-1:0] ck_sum;

    logic len_sh, rx_sh, ck_clr, ck_add;
    logic emit, fend, hdr_set, err_set, done_set;
    logic [7:0] emit_val;
    logic       exp_bit;

    // byte mode needs whole bytes per frame
    generate
        if (FRAME_BITS % 8 != 0) begin : g_bad_frame
            initial $error("FRAME_BITS must be a multiple of 8");
        end
    endgenerate

    cfgp_shreg #(.W(LEN_W)) u_len (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (len_sh),
        .din   (in_bit),
        .q     (len_q)
    );

    cfgp_shreg #(.W(CHK_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (rx_sh),
        .din   (in_bit),
        .q     (rx_q)
    );

    cfgp_ckacc #(.W(CHK_W)) u_ck (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ck_clr),
        .add   (ck_add),
        .bit_i (in_bit),
        .sum   (ck_sum)
    );

    // next-state and control decode
    always_comb begin
        nxt      = state;
        cnt_n    = cnt;
        used_n   = used;
        frames_n = frames;
        len_sh   = 1'b0;
        rx_sh    = 1'b0;
        ck_clr   = 1'b0;
        ck_add   = 1'b0;
        emit     = 1'b0;
        emit_val = '0;
        fend     = 1'b0;
        hdr_set  = 1'b0;
        err_set  = 1'b0;
        done_set = 1'b0;
        exp_bit  = 1'b0;

        if (state == ST_IDLE) begin
            cur = wide_mode ? XT_ONES : ST_ONES;
            nxt = cur;
        end else begin
            cur = state;
        end

        if (in_valid) begin
            unique case (cur)
                ST_ONES: begin
                    if (in_bit) begin
                        if (cnt < ONES_MIN) cnt_n = cnt + 1'b1;
                    end else if (cnt == ONES_MIN) begin
                        nxt   = ST_PRE;
                        cnt_n = CNT_W'(1);
                    end else begin
                        err_set = 1'b1;
                    end
                end
                ST_PRE: begin
                    exp_bit = PRE_CODE[2'(3 - cnt)];
                    if (in_bit != exp_bit) begin
                        err_set = 1'b1;
                    end else if (cnt == LAST_CHK) begin
                        nxt   = ST_LEN;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                ST_LEN: begin
                    len_sh = 1'b1;
                    if (cnt == LAST_LEN) begin
                        nxt   = ST_SEP;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                ST_SEP: begin
                    if (!in_bit) begin
                        err_set = 1'b1;
                    end else if (cnt == LAST_SEP) begin
                        hdr_set = 1'b1;
                        cnt_n   = '0;
                        used_n  = '0;
                        nxt     = (len_q == '0) ? ST_POST : ST_FSTART;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                ST_FSTART: begin
                    if (in_bit) begin
                        err_set = 1'b1;
                    end else begin
                        nxt    = ST_FDATA;
                        used_n = used + 1'b1;
                        ck_clr = 1'b1;
                        cnt_n  = '0;
                    end
                end
                ST_FDATA: begin
                    emit     = 1'b1;
                    emit_val = {7'b0, in_bit};
                    ck_add   = 1'b1;
                    used_n   = used + 1'b1;
                    if (cnt == LAST_DATA) begin
                        nxt   = ST_FCHK;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                ST_FCHK: begin
                    rx_sh  = 1'b1;
                    used_n = used + 1'b1;
                    if (cnt == LAST_CHK) begin
                        cnt_n = '0;
                        if ({rx_q[CHK_W-2:0], in_bit} != ck_sum) begin
                            err_set = 1'b1;
                        end else begin
                            fend = 1'b1;
                            if (used_n == len_q) begin
                                nxt = ST_POST;
                            end else if (used_n > len_q) begin
                                err_set = 1'b1;
                            end else begin
                                nxt = ST_FSTART;
                            end
                        end
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                ST_POST: begin
                    exp_bit = POST_CODE[2'(3 - cnt)];
                    if (in_bit != exp_bit) begin
                        err_set = 1'b1;
                    end else if (cnt == LAST_CHK) begin
                        nxt   = ST_BOOT;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                ST_BOOT, XT_BOOT: begin
                    if (cnt == LAST_BOOT) begin
                        nxt      = ST_DONE;
                        done_set = 1'b1;
                        cnt_n    = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                XT_ONES: begin
                    if (in_byte != X_ONES_BYTE) err_set = 1'b1;
                    else                        nxt     = XT_PRE;
                end
                XT_PRE: begin
                    if (in_byte[3:0] != X_PRE_NIB) begin
                        err_set = 1'b1;
                    end else begin
                        nxt   = XT_FILL;
                        cnt_n = '0;
                    end
                end
                XT_FILL: begin
                    if (cnt == LAST_FILL) begin
                        hdr_set  = 1'b1;
                        nxt      = XT_FDATA;
                        cnt_n    = '0;
                        frames_n = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                XT_FDATA: begin
                    emit     = 1'b1;
                    emit_val = in_byte;
                    if (cnt == LAST_BYTE) begin
                        fend  = 1'b1;
                        cnt_n = '0;
                        if (frames == LAST_FR) nxt = XT_BOOT;
                        else                   frames_n = frames + 1'b1;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                default: begin
                    // DONE and ERR consume items without effect
                end
            endcase
        end

        if (err_set) nxt = ST_ERR;
    end

    // state register and field counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            used   <= '0;
            frames <= '0;
        end else begin
            state  <= nxt;
            cnt    <= cnt_n;
            used   <= used_n;
            frames <= frames_n;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_valid <= 1'b0;
            dout       <= '0;
            frame_end  <= 1'b0;
            header_ok  <= 1'b0;
            done       <= 1'b0;
            err        <= 1'b0;
        end else begin
            dout_valid <= emit;
            dout       <= emit_val;
            frame_end  <= fend;
            header_ok  <= header_ok | hdr_set;
            done       <= done | done_set;
            err        <= err | err_set;
        end
    end

endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker (
    input logic clk,
    input logic rst_n,
    input logic wide_mode,
    input logic in_valid,
    input logic dout_valid,
    input logic frame_end,
    input logic header_ok,
    input logic done,
    input logic err
);

    p_hdr_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        header_ok |=> header_ok);

    p_data_after_hdr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> header_ok);

    p_silent_after_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (!dout_valid && !frame_end));

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    p_stall_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!dout_valid && !frame_end));

    p_stall_no_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !done) |=> !done);

    p_stall_no_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !err) |=> !err);

    p_byte_fend_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_mode && frame_end) |-> dout_valid);

    p_err_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    p_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

endmodule

bind cfg_stream_parser cfgp_checker u_chk (.*);

// File: tb/sim_cfg_stream_parser.sv
`timescale 1ns/1ps
module sim_cfg_stream_parser;

    localparam int FB   = 16;
    localparam int SEPB = 4;
    localparam int XFR  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wide_mode = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_bit = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       dout_valid;
    logic [7:0] dout;
    logic       frame_end;
    logic       header_ok;
    logic       done;
    logic       err;

    int checks = 0;
    int errors = 0;
    bit gaps = 1'b0;
    int bitno = 0;
    // item: [9] marker, [8] frame_end expected, [7:0] data
    logic [9:0] sbq[$];

    always #2.5 clk = ~clk;

    cfg_stream_parser #(.FRAME_BITS(FB), .SEP_BITS(SEPB), .LEN_W(24), .EXP_FRAMES(XFR)) u0 (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .in_valid(in_valid),
        .in_bit(in_bit), .in_byte(in_byte), .dout_valid(dout_valid), .dout(dout),
        .frame_end(frame_end), .header_ok(header_ok), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard as results leave the design
    always @(negedge clk) begin
        if (rst_n) begin
            if (dout_valid) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R4", "unexpected data item", int'(dout), -1);
                end else begin
                    logic [9:0] it;
                    it = sbq.pop_front();
                    chk(!it[9] && dout == it[7:0], "R4 R11", "data value", int'(dout), int'(it[7:0]));
                    chk(frame_end == it[8], "R11", "frame_end with data", int'(frame_end), int'(it[8]));
                end
            end else if (frame_end) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R4", "unexpected frame_end", 1, 0);
                end else begin
                    logic [9:0] it;
                    it = sbq.pop_front();
                    chk(it[9], "R4", "frame_end instead of data", 1, 0);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "ALL", "watchdog expired", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic do_reset(input bit w);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        wide_mode = w;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        sbq.delete();
        bitno = 0;
    endtask

    task automatic pause();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic put_bit(input bit b);
        if (gaps && (bitno % 3 == 2)) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_bit = b;
        bitno++;
    endtask

    task automatic put_byte(input logic [7:0] v);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte = v;
    endtask

    task automatic hdr(input int ones, input logic [3:0] pre, input logic [23:0] len, input int sep_bad);
        for (int i = 0; i < ones; i++) put_bit(1'b1);
        for (int i = 3; i >= 0; i--) put_bit(pre[i]);
        for (int i = 23; i >= 0; i--) put_bit(len[i]);
        for (int i = 0; i < SEPB; i++) put_bit(i == sep_bad ? 1'b0 : 1'b1);
    endtask

    task automatic frame(input logic [FB-1:0] d, input bit bad_start, input bit bad_ck);
        logic [3:0] ck;
        put_bit(bad_start);
        if (!bad_start) begin
            for (int i = 0; i < FB; i++) begin
                sbq.push_back({2'b00, 7'b0, d[i]});
                put_bit(d[i]);
            end
            ck = 4'($countones(d)) ^ {3'b0, bad_ck};
            for (int i = 3; i >= 0; i--) put_bit(ck[i]);
            if (!bad_ck) sbq.push_back(10'b10_0000_0000);
        end
    endtask

    task automatic tail(input logic [3:0] post);
        for (int i = 3; i >= 0; i--) put_bit(post[i]);
    endtask

    task automatic junk_bits(input int n);
        for (int i = 0; i < n; i++) put_bit(1'($urandom));
    endtask

    task automatic xframe(input int nfr);
        for (int f = 0; f < nfr; f++) begin
            for (int k = 0; k < FB / 8; k++) begin
                logic [7:0] v;
                v = 8'($urandom);
                sbq.push_back({1'b0, (k == FB / 8 - 1), v});
                put_byte(v);
            end
        end
    endtask

    task automatic end_test();
        pause();
        pause();
        chk(sbq.size() == 0, "R4", "scoreboard drained", sbq.size(), 0);
        chk(!(done && err), "R13", "done and err together", int'(done && err), 0);
    endtask

    initial begin
        // R1: reset state
        do_reset(1'b0);
        pause();
        chk({dout_valid, frame_end, header_ok, done, err} == 5'b0, "R1", "outputs after reset",
            int'({dout_valid, frame_end, header_ok, done, err}), 0);

        // serial good stream with stalls, R2 R4 R6 R8 R9
        gaps = 1'b1;
        hdr(10, 4'b0010, 24'd42, -1);
        pause();
        chk(header_ok, "R2", "header_ok after separator", int'(header_ok), 1);
        frame(16'hA5C3, 1'b0, 1'b0);
        pause();
        for (int i = 0; i < 4; i++) begin
            pause();
            chk(!dout_valid && !frame_end, "R9", "quiet while in_valid low", int'(dout_valid), 0);
        end
        frame(16'hFFFF, 1'b0, 1'b0);
        tail(4'b0110);
        junk_bits(3);
        pause();
        chk(!done, "R8", "done not before fourth start-up item", int'(done), 0);
        junk_bits(1);
        pause();
        chk(done && !err, "R8", "done after start-up items", int'(done), 1);
        junk_bits(12);
        pause();
        chk(done && !err, "R8", "done holds after extra input", int'(done), 1);
        end_test();
        gaps = 1'b0;

        // R6: zero length goes straight to postamble
        do_reset(1'b0);
        hdr(8, 4'b0010, 24'd0, -1);
        tail(4'b0110);
        junk_bits(4);
        pause();
        chk(done && !err, "R6", "zero length stream completes", int'(done), 1);
        end_test();

        // R5: check mismatch
        do_reset(1'b0);
        hdr(8, 4'b0010, 24'd42, -1);
        frame(16'h1234, 1'b0, 1'b1);
        pause();
        chk(err, "R5", "err on bad check", int'(err), 1);
        junk_bits(30);
        end_test();
        chk(err && !done, "R13", "err sticky after bad check", int'(err), 1);

        // R5: bad start bit
        do_reset(1'b0);
        hdr(8, 4'b0010, 24'd42, -1);
        frame(16'h0F0F, 1'b1, 1'b0);
        pause();
        chk(err, "R5", "err on start bit of 1", int'(err), 1);
        junk_bits(25);
        end_test();

        // R3: zero inside separator
        do_reset(1'b0);
        hdr(8, 4'b0010, 24'd42, 2);
        pause();
        chk(err && !header_ok, "R3", "err on separator zero", int'(err), 1);
        end_test();

        // R3: only seven leading ones
        do_reset(1'b0);
        hdr(7, 4'b0010, 24'd42, -1);
        pause();
        chk(err, "R3", "err on short ones run", int'(err), 1);
        end_test();

        // R3: wrong preamble
        do_reset(1'b0);
        hdr(8, 4'b0011, 24'd42, -1);
        pause();
        chk(err && !header_ok, "R3", "err on bad preamble", int'(err), 1);
        end_test();

        // R7: wrong postamble
        do_reset(1'b0);
        hdr(8, 4'b0010, 24'd0, -1);
        tail(4'b0111);
        pause();
        chk(err, "R7", "err on bad postamble", int'(err), 1);
        junk_bits(4);
        end_test();
        chk(!done, "R7", "no done after bad postamble", int'(done), 0);

        // R6: length not on a frame boundary
        do_reset(1'b0);
        hdr(8, 4'b0010, 24'd30, -1);
        frame(16'h8001, 1'b0, 1'b0);
        pause();
        chk(!err, "R6", "no err while under length", int'(err), 0);
        frame(16'h7E7E, 1'b0, 1'b0);
        pause();
        chk(err, "R6", "err on length overrun", int'(err), 1);
        end_test();

        // R10 R11: byte mode good stream
        do_reset(1'b1);
        put_byte(8'hFF);
        put_byte(8'hB4);
        for (int i = 0; i < 3; i++) put_byte(8'($urandom));
        pause();
        chk(header_ok, "R10", "byte header_ok", int'(header_ok), 1);
        xframe(XFR);
        for (int i = 0; i < 3; i++) put_byte(8'($urandom));
        pause();
        chk(!done, "R11", "byte done not early", int'(done), 0);
        put_byte(8'h00);
        pause();
        chk(done && !err, "R11", "byte done after start-up", int'(done), 1);
        for (int i = 0; i < 5; i++) put_byte(8'($urandom));
        end_test();

        // R12: bad first byte
        do_reset(1'b1);
        put_byte(8'hFE);
        pause();
        chk(err, "R12", "err on bad ones byte", int'(err), 1);
        end_test();

        // R12: bad preamble nibble
        do_reset(1'b1);
        put_byte(8'hFF);
        put_byte(8'h42);
        pause();
        chk(err && !header_ok, "R12", "err on bad preamble byte", int'(err), 1);
        for (int i = 0; i < 8; i++) put_byte(8'($urandom));
        end_test();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule